// File: doc/BRIEF.md
# Static RAM Retention Power Sequencer

This block steps a battery-backed static RAM into a low-voltage retention condition and back out again. When asked to sleep, it first forces the memory into standby. It does this by pulling the memory's active-high chip select low. Only after that does it tell an external regulator to drop the supply to the retention level. On wake-up, it returns the regulator to the operating level. It then waits until a synchronized supply-good signal reports the rail back in range, and holds off for a recovery interval sized from the clock frequency. Only then does it re-open the gate toward the access controller.

Access requests that arrive during the sleep, retention or recovery phases are not lost. They stay pending in the access controller, because the grant output is held low throughout. A wake request that arrives while standby is still being established is remembered and serviced as soon as retention has been reached. The current phase is reported on a three-bit status output.

Top module: `sram_ret_seq`

## Requirements
- R1: Under reset and on leaving it, the phase is RUN, status code 0. In RUN, `acc_grant` is 1 and both `mem_sel_park` and `vreg_retain` are 0. A reset in any phase returns the block to RUN.
- R2: A `sleep_req` sampled high in RUN moves the block to PARK (code 1) on the next clock. In PARK, `mem_sel_park` is 1, `acc_grant` is 0 and `vreg_retain` is 0.
- R3: PARK lasts exactly PARK_CYCLES+1 clocks, then HOLD (code 2) follows. In HOLD, `vreg_retain` is 1, `mem_sel_park` is 1 and `acc_grant` is 0. `vreg_retain` never rises unless `mem_sel_park` was already 1 in the previous cycle.
- R4: A `wake_req` sampled high in HOLD moves the block to RAMP (code 3) on the next clock. In RAMP, `vreg_retain` is 0, `mem_sel_park` is 1 and `acc_grant` is 0.
- R5: A `wake_req` seen during PARK is remembered. HOLD then lasts exactly one clock before RAMP, with no further wake request needed.
- R6: `supply_ok` passes through a SYNC_STAGES-flop synchronizer. RAMP moves to SETTLE (code 4) on the clock after the synchronized value is 1.
- R7: SETTLE lasts RECOVER_CYCLES+1 clocks, with RECOVER_CYCLES = CLK_HZ*RECOVER_US/1e6, and is then followed by RUN. `acc_grant` stays 0 from PARK until that return, and it rises only right after a completed recovery count.
- R8: If the synchronized `supply_ok` is 0 during SETTLE, the block goes back to RAMP on the next clock. When it next enters SETTLE, the recovery count starts again from zero.
- R9: `sleep_req` has no effect outside RUN. `wake_req` has no effect in RUN, RAMP or SETTLE, and it is not remembered for a later sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Request to enter retention, sampled in RUN |
| wake_req | input | 1 | Request to leave retention, sampled in PARK and HOLD |
| supply_ok | input | 1 | Supply in operating range, asynchronous |
| vreg_retain | output | 1 | 1 selects the retention supply level at the regulator |
| mem_sel_park | output | 1 | 1 forces the memory's active-high chip select low |
| acc_grant | output | 1 | 1 lets the access controller issue reads and writes |
| state_code | output | 3 | Phase: 0 RUN, 1 PARK, 2 HOLD, 3 RAMP, 4 SETTLE |

## Verification
Two pairs of functions can land in the same cycle. In the first, a wake request arrives while the standby timer is still running in PARK. The bench provokes this inside the vector table and judges it by HOLD lasting exactly one cycle before RAMP appears. In the second, a supply-good dropout falls inside a recovery count that is already partly done. The bench drops `supply_ok` for one cycle mid-SETTLE and expects the return to RAMP exactly two clocks later. It then expects a full fresh SETTLE count, followed by an unchanged RUN re-entry. A sleep request fired during SETTLE checks that a stray request cannot shorten the recovery.

// File: rtl/ret_seq_pkg.sv
package ret_seq_pkg;

   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_PARK   = 3'd1,
      ST_HOLD   = 3'd2,
      ST_RAMP   = 3'd3,
      ST_SETTLE = 3'd4
   } seq_st_t;

   typedef struct packed {
      logic retain;
      logic park;
      logic grant;
   } seq_out_t;

   function automatic seq_out_t decode_outputs(seq_st_t st);
      seq_out_t o;
      o.retain = (st == ST_HOLD);
      o.park   = (st != ST_RUN);
      o.grant  = (st == ST_RUN);
      return o;
   endfunction

endpackage

// File: rtl/ret_seq_sync.sv
module ret_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("ret_seq_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d_in;
         end
         assign d_out = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], d_in};
         end
         assign d_out = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ret_seq_timer.sv
module ret_seq_timer #(
   parameter int COUNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int W = (COUNT < 1) ? 1 : $clog2(COUNT + 1);
   localparam logic [W-1:0] LIMIT = W'(COUNT);

   generate
      if (COUNT < 1) begin : g_bad_count
         $error("ret_seq_timer: COUNT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == LIMIT);

   // R7: the count never passes its limit
   a_r7_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   // R7: a count that has not been stopped advances by exactly one
   a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != LIMIT) |=> (!run || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sram_ret_seq.sv
module sram_ret_seq
   import ret_seq_pkg::*;
#(
   parameter longint CLK_HZ      = 100_000_000,
   parameter longint RECOVER_US  = 5000,
   parameter int     PARK_CYCLES = 4,
   parameter int     SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       wake_req,
   input  logic       supply_ok,
   output logic       vreg_retain,
   output logic       mem_sel_park,
   output logic       acc_grant,
   output logic [2:0] state_code
);

   localparam longint RECOVER_L      = (CLK_HZ * RECOVER_US) / 64'd1_000_000;
   localparam int     RECOVER_CYCLES = int'(RECOVER_L);

   generate
      if (RECOVER_CYCLES < 1) begin : g_bad_recover
         $error("sram_ret_seq: recovery interval rounds to zero cycles");
      end
      if (PARK_CYCLES < 1) begin : g_bad_park
         $error("sram_ret_seq: PARK_CYCLES must be at least 1");
      end
   endgenerate

   seq_st_t  st_q, st_d;
   logic     wake_pend_q;
   logic     good_s;
   logic     park_done;
   logic     settle_done;
   seq_out_t outs;

   ret_seq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (supply_ok),
      .d_out (good_s)
   );

   ret_seq_timer #(.COUNT(PARK_CYCLES)) i_park_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_PARK),
      .done  (park_done)
   );

   ret_seq_timer #(.COUNT(RECOVER_CYCLES)) i_settle_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_SETTLE),
      .done  (settle_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:    if (sleep_req) st_d = ST_PARK;
         ST_PARK:   if (park_done) st_d = ST_HOLD;
         ST_HOLD:   if (wake_req || wake_pend_q) st_d = ST_RAMP;
         ST_RAMP:   if (good_s) st_d = ST_SETTLE;
         ST_SETTLE: begin
            if (!good_s)          st_d = ST_RAMP;
            else if (settle_done) st_d = ST_RUN;
         end
         default:   st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_RUN;
         wake_pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_PARK && wake_req) wake_pend_q <= 1'b1;
         else if (st_q != ST_PARK)        wake_pend_q <= 1'b0;
      end
   end

   assign outs         = decode_outputs(st_q);
   assign vreg_retain  = outs.retain;
   assign mem_sel_park = outs.park;
   assign acc_grant    = outs.grant;
   assign state_code   = st_q;

   // R2: a sleep request in RUN parks the memory next cycle
   a_r2_sleep_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && sleep_req) |=> (st_q == ST_PARK));

   // R3: the regulator is never told to drop before standby is held
   a_r3_park_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vreg_retain) |-> $past(mem_sel_park));

   // R5: a remembered wake leaves HOLD at once
   a_r5_pend_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD && wake_pend_q) |=> (st_q == ST_RAMP));

   // R7: access is only re-granted after a completed recovery count
   a_r7_grant_after_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_grant) |-> $past(settle_done));

   // R8: loss of supply during recovery returns to waiting for it
   a_r8_dropout: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SETTLE && !good_s) |=> (st_q == ST_RAMP));

   // R9: retention level is asserted only with access blocked
   a_r9_no_access_low: assert property (@(posedge clk) disable iff (!rst_n)
      vreg_retain |-> !acc_grant);

endmodule

// File: tb/test_sram_ret_seq.sv
module test_sram_ret_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       wake_req = 1'b0;
   logic       supply_ok = 1'b1;
   logic       vreg_retain, mem_sel_park, acc_grant;
   logic [2:0] state_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sram_ret_seq #(
      .CLK_HZ(1_000_000), .RECOVER_US(6), .PARK_CYCLES(2), .SYNC_STAGES(2)
   ) i_sram_ret_seq (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .supply_ok(supply_ok), .vreg_retain(vreg_retain),
      .mem_sel_park(mem_sel_park), .acc_grant(acc_grant),
      .state_code(state_code)
   );

   // row: {sleep, wake, supply_ok, state[2:0], grant, park, retain}
   localparam int NV = 38;
   localparam logic [8:0] VEC [0:NV-1] = '{
      9'b001_000_100, 9'b101_001_010, 9'b001_001_010, 9'b001_001_010,
      9'b001_010_011, 9'b000_010_011, 9'b000_010_011, 9'b010_011_010,
      9'b000_011_010, 9'b001_011_010, 9'b001_011_010, 9'b001_100_010,
      9'b001_100_010, 9'b001_100_010, 9'b001_100_010, 9'b001_100_010,
      9'b001_100_010, 9'b001_100_010, 9'b001_000_100, 9'b011_000_100,
      9'b101_001_010, 9'b011_001_010, 9'b001_001_010, 9'b001_010_011,
      9'b001_011_010, 9'b001_100_010, 9'b101_100_010, 9'b000_100_010,
      9'b001_100_010, 9'b001_011_010, 9'b001_100_010, 9'b001_100_010,
      9'b001_100_010, 9'b001_100_010, 9'b001_100_010, 9'b001_100_010,
      9'b001_100_010, 9'b001_000_100
   };

   function automatic string tag_of(int i);
      if (i == 0)  return "R1";
      if (i == 1 || i == 20) return "R2";
      if (i <= 4)  return "R3";
      if (i <= 7)  return "R4";
      if (i <= 10 || i == 25) return "R6";
      if (i == 19 || i == 26) return "R9";
      if (i <= 18) return "R7";
      if (i <= 24) return "R5";
      if (i <= 29) return "R8";
      return "R7";
   endfunction

   task automatic check(string req, logic [5:0] exp);
      logic [5:0] act;
      act = {state_code, acc_grant, mem_sel_park, vreg_retain};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: state/grant/park/retain actual %b expected %b",
                  req, act, exp);
      end
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", 6'b000_100);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         sleep_req = VEC[i][8];
         wake_req  = VEC[i][7];
         supply_ok = VEC[i][6];
         @(negedge clk);
         check(tag_of(i), VEC[i][5:0]);
      end
      // R1: reset taken in HOLD returns to RUN
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      repeat (3) @(negedge clk);
      check("R3", 6'b010_011);
      rst_n = 1'b0;
      #1;
      check("R1", 6'b000_100);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: wake in RUN is not remembered for the next sleep
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      repeat (4) @(negedge clk);
      check("R9", 6'b010_011);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule